// File: doc/BRIEF.md
# Soft Threshold Arbiter for Four Clients

This block shares a budget of power among four requesting clients. It does not hand out a fixed number of grants. Every pair of clients has its own ranker that remembers which of the two asked first. Each client then counts the pairs it wins. A client is granted once its win count reaches a threshold taken from an 8-bit softness register. With the right thresholds, the block usually admits a fixed share of the clients and lets one extra client through only for some rare ranking patterns. The block therefore acts as a valve that software can tune. A register value of zero treats every client alike.

A client whose request was already seen beats any client that is not requesting, and it beats any client that arrives later. When several requests arrive in the same cycle, a linear-feedback shift register breaks the tie for each pair. This is how cyclic rankings arise: A beats B, B beats C and C beats A. A grant stays set until its request is withdrawn. The softness register may only be written while every request is low. A write attempted at any other time is dropped and sets a sticky error flag.

Top module: `soft_valve_arbiter`

## Requirements
- R1: While reset is low and just after it is released, every grant is 0, the error flag is 0 and the softness register is 0.
- R2: Pair rankers are indexed k=0..5 as (0,1),(0,2),(0,3),(1,2),(1,3),(2,3), with the lower client first. In each pair, a client whose request rose earlier beats the other. An active client also beats a client whose request is low.
- R3: A client is granted when its request is active and its pairwise win count is at least its threshold. The grant first shows after the second rising edge at which the request is sampled high.
- R4: Client i takes its threshold from the field {scr[2i+1],scr[2i]}. The field value 01 means one win, 10 means two wins and 11 means three wins. The value 00 falls back to one win.
- R5: When all thresholds are two (scr=8'hAA) and the four clients arrive one by one, exactly the first two arrivals are granted.
- R6: When two or more requests rise in the same cycle, each pair k that rises together takes bit k of the shift register, where 1 means the lower client wins. The register starts at 8'hA5 and steps as {s[6:0], s[7]^s[5]^s[4]^s[3]}. It steps exactly once on each edge where two or more requests rise.
- R7: With scr=8'hAA, a cyclic table with win counts 2,2,2,0 yields three grants, and win counts 3,1,1,1 yield one grant.
- R8: A grant stays set while its request stays high. It drops one edge after its request is sampled low.
- R9: A write strobe sampled while all requests are low loads the write data into the softness register at that edge.
- R10: A write strobe sampled while any request is high leaves the softness register unchanged. It sets the error flag, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| req | input | 4 | Request per client, held high until the client is done |
| cfgWrEn | input | 1 | Write strobe for the softness register |
| cfgWrData | input | 8 | Softness register write data, two bits per client |
| grant | output | 4 | Registered grant per client |
| cfgErr | output | 1 | Sticky flag for a write attempted while a request was high |

## Verification
The checker takes for granted that a client keeps its request high until it has finished with it. It also assumes that write strobes last one cycle. The bench drives only such level-held requests, and it strobes writes for a single cycle. The bench separates episodes by dropping every request for two cycles. It models the tie-break register from R6 so that it can predict which pair tables the arbiter forms. It then confirms that both of the rare R7 patterns actually occurred.

// File: rtl/soft_valve_pkg.sv
package soft_valve_pkg;
  localparam int CLIENTS = 4;
  localparam int PAIRS   = CLIENTS * (CLIENTS - 1) / 2;
  localparam int FIELD_W = 2;
  localparam int SCR_W   = CLIENTS * FIELD_W;
  localparam int CNT_W   = $clog2(CLIENTS);
  localparam int LFSR_W  = 8;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8;

  typedef struct packed {
    logic [CLIENTS-1:0] active;
    logic [CLIENTS-1:0] rise;
    logic [PAIRS-1:0]   tieBit;
    logic               cfgLoad;
  } strobe_t;

  // lower client of pair k
  function automatic int pairLo(input int k);
    int idx = 0;
    int res = 0;
    for (int a = 0; a < CLIENTS; a++)
      for (int b = a + 1; b < CLIENTS; b++) begin
        if (idx == k) res = a;
        idx++;
      end
    return res;
  endfunction

  // upper client of pair k
  function automatic int pairHi(input int k);
    int idx = 0;
    int res = 0;
    for (int a = 0; a < CLIENTS; a++)
      for (int b = a + 1; b < CLIENTS; b++) begin
        if (idx == k) res = b;
        idx++;
      end
    return res;
  endfunction

  function automatic int thrOf(input logic [FIELD_W-1:0] f);
    return (f == '0) ? 1 : int'(f);
  endfunction
endpackage

// File: rtl/soft_valve_ctrl.sv
module soft_valve_ctrl
  import soft_valve_pkg::*;
#(
  parameter logic [LFSR_W-1:0] LFSR_SEED = 8'hA5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CLIENTS-1:0] req,
  input  logic               cfgWrEn,
  output strobe_t            stb,
  output logic               cfgErr
);
  logic [CLIENTS-1:0] prevReq;
  logic [LFSR_W-1:0]  lfsr;
  logic [CLIENTS-1:0] rise;
  logic               multiRise;
  logic               anyReq;

  assign rise      = req & ~prevReq;
  assign multiRise = $countones(rise) > 1;
  assign anyReq    = |req;

  assign stb.active  = req & prevReq;
  assign stb.rise    = rise;
  assign stb.tieBit  = lfsr[PAIRS-1:0];
  assign stb.cfgLoad = cfgWrEn & ~anyReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevReq <= '0;
      lfsr    <= LFSR_SEED;
      cfgErr  <= 1'b0;
    end else begin
      prevReq <= req;
      if (multiRise) lfsr <= {lfsr[LFSR_W-2:0], ^(lfsr & LFSR_TAPS)};
      if (cfgWrEn && anyReq) cfgErr <= 1'b1;
    end
  end
endmodule

// File: rtl/soft_valve_dp.sv
module soft_valve_dp
  import soft_valve_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [SCR_W-1:0]   cfgWrData,
  output logic [CLIENTS-1:0] grant
);
  logic [SCR_W-1:0]   scr;
  logic [PAIRS-1:0]   winLo;
  logic [PAIRS-1:0]   winHi;
  logic [CNT_W-1:0]   winCnt [CLIENTS];
  logic [CLIENTS-1:0] met;

  always_ff @(posedge clk) begin
    if (!rstN) scr <= '0;
    else if (stb.cfgLoad) scr <= cfgWrData;
  end

  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    localparam int A = pairLo(k);
    localparam int B = pairHi(k);
    logic loBeats;
    always_ff @(posedge clk) begin
      if (!rstN) loBeats <= 1'b1;
      else if (stb.rise[A] && stb.rise[B]) loBeats <= stb.tieBit[k];
      else if (stb.rise[B]) loBeats <= 1'b1;
      else if (stb.rise[A]) loBeats <= 1'b0;
    end
    assign winLo[k] = stb.active[A] & (~stb.active[B] | loBeats);
    assign winHi[k] = stb.active[B] & (~stb.active[A] | ~loBeats);
  end

  always_comb begin
    for (int c = 0; c < CLIENTS; c++) begin
      winCnt[c] = '0;
      for (int k = 0; k < PAIRS; k++) begin
        if (pairLo(k) == c) winCnt[c] = winCnt[c] + CNT_W'(winLo[k]);
        if (pairHi(k) == c) winCnt[c] = winCnt[c] + CNT_W'(winHi[k]);
      end
      met[c] = int'(winCnt[c]) >= thrOf(scr[FIELD_W*c +: FIELD_W]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) grant <= '0;
    else grant <= stb.active & (grant | met);
  end
endmodule

// File: rtl/soft_valve_arbiter.sv
module soft_valve_arbiter
  import soft_valve_pkg::*;
#(
  parameter logic [LFSR_W-1:0] LFSR_SEED = 8'hA5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CLIENTS-1:0] req,
  input  logic               cfgWrEn,
  input  logic [SCR_W-1:0]   cfgWrData,
  output logic [CLIENTS-1:0] grant,
  output logic               cfgErr
);
  strobe_t stb;

  soft_valve_ctrl #(.LFSR_SEED(LFSR_SEED)) ctrlI (
    .clk(clk), .rstN(rstN), .req(req), .cfgWrEn(cfgWrEn),
    .stb(stb), .cfgErr(cfgErr)
  );

  soft_valve_dp dpI (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgWrData(cfgWrData), .grant(grant)
  );
endmodule

// File: rtl/soft_valve_chk.sv
module soft_valve_chk
  import soft_valve_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [CLIENTS-1:0] req,
  input logic               cfgWrEn,
  input logic [CLIENTS-1:0] grant,
  input logic               cfgErr
);
  for (genvar i = 0; i < CLIENTS; i++) begin : g_cli
    // R8
    drop_on_withdraw_chk: assert property (@(posedge clk) disable iff (!rstN)
      !req[i] |=> !grant[i]);
    // R8
    hold_while_req_chk: assert property (@(posedge clk) disable iff (!rstN)
      (grant[i] && req[i]) |=> grant[i]);
    // R3
    grant_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(grant[i]) |-> ($past(req[i]) && $past(req[i], 2)));
  end

  // R10
  err_on_busy_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && (|req)) |=> cfgErr);
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |=> cfgErr);
endmodule

bind soft_valve_arbiter soft_valve_chk chkI (
  .clk(clk), .rstN(rstN), .req(req), .cfgWrEn(cfgWrEn),
  .grant(grant), .cfgErr(cfgErr)
);

// File: tb/soft_valve_arbiter_test.sv
module soft_valve_arbiter_test;
  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] req;
  logic       cfgWrEn;
  logic [7:0] cfgWrData;
  logic [3:0] grant;
  logic       cfgErr;

  always #10 clk = ~clk;

  soft_valve_arbiter uut (
    .clk(clk), .rstN(rstN), .req(req), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .grant(grant), .cfgErr(cfgErr)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // model state, built from the requirements
  logic [7:0] mLfsr;
  logic [5:0] mBeat;
  logic [3:0] mReq;
  logic [3:0] mGrant;
  logic [7:0] mScr;
  logic       mErr;
  localparam int PA [6] = '{0, 0, 0, 1, 1, 2};
  localparam int PB [6] = '{1, 2, 3, 2, 3, 3};

  // vectors: {scr, stage0, stage1, stage2, stage3}
  localparam int NVEC = 7;
  localparam logic [23:0] VEC [NVEC] = '{
    {8'h00, 4'h1, 4'h2, 4'h4, 4'h8},
    {8'hAA, 4'h1, 4'h2, 4'h4, 4'h8},
    {8'hFF, 4'h8, 4'h4, 4'h2, 4'h1},
    {8'h55, 4'h4, 4'h0, 4'h0, 4'h0},
    {8'hAA, 4'h2, 4'h8, 4'h0, 4'h0},
    {8'hE4, 4'h8, 4'h4, 4'h2, 4'h1},
    {8'hAA, 4'h3, 4'h4, 4'hC, 4'h0}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int thrM(input int c);
    logic [1:0] f;
    f = mScr[2*c +: 2];
    return (f == 2'b00) ? 1 : int'(f);
  endfunction

  task automatic modelStep(input logic [3:0] nr);
    logic [3:0] rise;
    int cnt [4];
    rise = nr & ~mReq;
    for (int k = 0; k < 6; k++) begin
      if (rise[PA[k]] && rise[PB[k]]) mBeat[k] = mLfsr[k];
      else if (rise[PB[k]]) mBeat[k] = 1'b1;
      else if (rise[PA[k]]) mBeat[k] = 1'b0;
    end
    if ($countones(rise) > 1) mLfsr = {mLfsr[6:0], mLfsr[7] ^ mLfsr[5] ^ mLfsr[4] ^ mLfsr[3]};
    mReq = nr;
    for (int c = 0; c < 4; c++) cnt[c] = 0;
    for (int k = 0; k < 6; k++) begin
      if (nr[PA[k]] && (!nr[PB[k]] || mBeat[k])) cnt[PA[k]]++;
      if (nr[PB[k]] && (!nr[PA[k]] || !mBeat[k])) cnt[PB[k]]++;
    end
    for (int c = 0; c < 4; c++)
      mGrant[c] = nr[c] & (mGrant[c] | (cnt[c] >= thrM(c)));
  endtask

  // called at a negedge; returns at a negedge two edges later
  task automatic drive(input logic [3:0] nr, input string tag);
    req = nr;
    modelStep(nr);
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(tag, {4'h0, grant}, {4'h0, mGrant});
  endtask

  task automatic cfgWrite(input logic [7:0] d);
    cfgWrEn = 1'b1;
    cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (mReq == 4'h0) mScr = d;
    else mErr = 1'b1;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    req = '0;
    cfgWrEn = 1'b0;
    cfgWrData = '0;
    repeat (3) @(negedge clk);
    mLfsr = 8'hA5; mBeat = 6'h3F; mReq = '0; mGrant = '0; mScr = '0; mErr = 1'b0;
    check("R1 grant in reset", {4'h0, grant}, 8'h0);
    check("R1 err in reset", {7'h0, cfgErr}, 8'h0);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int seen3;
    int seen1;
    doReset();
    check("R1 grant after reset", {4'h0, grant}, 8'h0);

    // R1 R4: default thresholds of one win, total order 0,1,2,3
    drive(4'h1, "R2 R3 single");
    drive(4'h3, "R2 second arrival");
    drive(4'h7, "R4 default thr");
    drive(4'hF, "R4 default thr last");
    check("R4 zero scr three grants", {4'h0, grant}, 8'h07);

    // table walk: R2 R4 R5 R6 R9
    for (int v = 0; v < NVEC; v++) begin
      logic [3:0] cur;
      drive(4'h0, "R8 clear");
      cfgWrite(VEC[v][23:16]);
      cur = 4'h0;
      for (int s = 0; s < 4; s++) begin
        cur = cur | VEC[v][15 - 4*s -: 4];
        drive(cur, "R4 R5 R6 R9 vector");
      end
    end
    check("R9 last write kept, no err", {7'h0, cfgErr}, 8'h0);

    // R5: explicit total order with 0xAA yields exactly two grants
    drive(4'h0, "R8 clear");
    cfgWrite(8'hAA);
    drive(4'h4, "R5 a"); drive(4'h6, "R5 b"); drive(4'h7, "R5 c"); drive(4'hF, "R5 d");
    check("R5 two grants", {4'h0, grant}, 8'h06);

    // R3: latency, grant absent after one edge, present after two
    drive(4'h0, "R8 clear");
    req = 4'h2; modelStep(4'h2);
    @(posedge clk); @(negedge clk);
    check("R3 no grant after one edge", {4'h0, grant}, 8'h00);
    @(posedge clk); @(negedge clk);
    check("R3 grant after two edges", {4'h0, grant}, 8'h02);

    // R8: hold then withdraw drops after one edge
    drive(4'h3, "R8 second joins");
    repeat (5) @(negedge clk);
    check("R8 held", {4'h0, grant}, 8'h03);
    req = 4'h1; modelStep(4'h1);
    @(posedge clk); @(negedge clk);
    check("R8 drop one edge", {4'h0, grant}, 8'h01);

    // R10: write while busy is ignored and flags error
    cfgWrite(8'h00);
    check("R10 err set", {7'h0, cfgErr}, 8'h1);
    drive(4'h0, "R8 clear");
    check("R10 err sticky", {7'h0, cfgErr}, 8'h1);
    drive(4'h1, "R10 a"); drive(4'h3, "R10 b"); drive(4'h7, "R10 c"); drive(4'hF, "R10 d");
    check("R10 scr unchanged (still AA)", {4'h0, grant}, 8'h03);

    // R6 R7: tie episodes with the modeled shift register
    seen3 = 0; seen1 = 0;
    for (int ep = 0; ep < 64; ep++) begin
      drive(4'h0, "R8 clear");
      if (ep % 2 == 0) drive(4'hF, "R6 four-way tie");
      else begin
        drive(4'h7, "R6 three-way tie");
        drive(4'hF, "R6 late fourth");
      end
      if (grant == mGrant && $countones(mGrant) == 3) seen3++;
      if (grant == mGrant && $countones(mGrant) == 1) seen1++;
    end
    check("R7 three-grant cyclic case seen", {7'h0, seen3 > 0}, 8'h1);
    check("R7 one-grant case seen", {7'h0, seen1 > 0}, 8'h1);

    // R1: reset clears the sticky flag
    doReset();
    check("R1 err cleared", {7'h0, cfgErr}, 8'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule